// File: doc/BRIEF.md
# I2C Clock-Calendar Register File

This block is an I2C target device holding a 64-byte register space. The lowest eight bytes hold a BCD clock and calendar; the remaining bytes are general storage. A bus master reaches any byte through one register pointer. The pointer is set by the first byte of a write transfer. It advances after every byte written or read, runs across the boundary between clock and storage bytes, and wraps from the last byte back to byte 0.

The clock advances once every `SUBTICKS` pulses of a timebase input. With `SUBTICKS` = 1 that input is a 1 Hz tick. Seconds carry into minutes, hours, day of week, date, month and year. The date follows month length, and February gains a 29th day when the two-digit year is a multiple of four. Hours can count in 24-hour form or in 12-hour form with a PM flag. A halt flag in the seconds byte freezes the clock. When the power-good input drops, the bus side goes quiet while the clock keeps counting.

SCL and SDA are oversampled in the system clock domain. SDA is driven open-drain: `sda_oe` high pulls the line low.

Top module: `rtc_regfile_i2c`

## Requirements
- R1: The device acknowledges an address byte only when its upper seven bits equal 7'h68. Bit 0 of that byte selects a read when 1 and a write when 0. For any other address, SDA is never pulled low until the next START.
- R2: In a write transfer, the first byte after the address loads the pointer from its low 6 bits. Each later byte is acknowledged, stored at the pointer, and the pointer then increments.
- R3: A read transfer returns bytes starting at the current pointer, which keeps its last value when no pointer write came first. The pointer increments after each byte. After the master answers a byte with NACK, SDA is released and stays released.
- R4: During multi-byte access the pointer wraps from 3Fh to 00h.
- R5: Bytes travel MSB first. A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A repeated START begins a new address phase. After reset and after a STOP the device leaves SDA released.
- R6: When bit 7 of byte 00h is 1, timebase pulses have no effect on any clock byte.
- R7: Seconds (byte 00h) and minutes (byte 01h) count in BCD from 00 to 59, and reaching 59 rolls over to 00 with a carry. One second passes every `SUBTICKS` timebase pulses.
- R8: With bit 6 of byte 02h at 0 (24-hour form), hours count 00 to 23 in bits 5:0, with bit 5 as the tens bit for hours 20 to 23. The step from 23 to 00 carries a day. At each day carry, day of week (byte 03h) steps 1..7 and goes from 7 back to 1.
- R9: With bit 6 of byte 02h at 1 (12-hour form), bits 4:0 hold hours 01 to 12 in BCD and bit 5 is PM. The step from 11 to 12 toggles PM, and only the step from 11 PM to 12 AM carries a day. The step from 12 goes to 01.
- R10: Date (byte 04h) rolls to 01 after 31, 30 (months 04, 06, 09, 11), 28, or 29 for month 02 when the BCD year in byte 06h is a multiple of four. Month (byte 05h) rolls from 12 to 01 with a year carry, and year rolls from 99 to 00.
- R11: A bus write to byte 00h restarts the sub-second count, so the next second passes a full `SUBTICKS` pulses later.
- R12: While `pwr_ok` is low, any transfer in progress ends, the pointer returns to 00h, and no byte is acknowledged or stored. Timekeeping continues.
- R13: Byte 07h and bytes 08h to 3Fh are plain storage that timekeeping never alters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset; clears all bytes |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | Pull SDA low when 1; release when 0 |
| tick_i | input | 1 | One-cycle timebase pulse, `SUBTICKS` per second |
| pwr_ok | input | 1 | Supply good; low blocks bus access |

## Verification
The assertions assume that SCL stays high and stays low for several system clocks, well beyond the three-stage sampling delay. They also assume SDA moves only inside the low phase of SCL, except for START and STOP, and that `tick_i` and `pwr_ok` are synchronous to `clk`. The bench keeps to this by holding every quarter of a bit period for eight clocks and by changing SDA one quarter after the SCL fall. It changes `tick_i` and `pwr_ok` only on the falling clock edge, and `tick_i` is a one-cycle pulse. Power is dropped only while SCL is low, and no timebase pulse arrives during a bus transfer, so read values depend on the tick counts alone.

// File: rtl/rtc_regfile_i2c.sv
module rtc_regfile_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int SUBTICKS = 4,
  parameter int AW = 6
)(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic tick_i,
  input  logic pwr_ok
);
  localparam int DEPTH = 1 << AW;
  localparam int SW = (SUBTICKS > 1) ? $clog2(SUBTICKS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_ACK, S_RD, S_RACK} st_t;

  st_t st;
  logic [2:0] scl_q, sda_q;
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [7:0] sh, tx;
  logic [3:0] cnt;
  logic rw, first, mack;
  logic [SW-1:0] sub;
  logic [7:0] n0, n1, n2, n3, n4, n5, n6, h12, h24;
  logic cmin, chr, cday, cmon, cyr;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire wr_en    = pwr_ok & ~start_c & ~stop_c & (st == S_WR) & scl_fall & (cnt == 4'd8) & ~first;
  wire halted   = mem[0][7];
  wire sec_step = tick_i & ~halted & (sub == SW'(SUBTICKS - 1));

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] mlen(input logic [7:0] m, input logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    case (m)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  always_comb begin
    cmin = (mem[0] == 8'h59);
    n0 = cmin ? 8'h00 : bcd_inc(mem[0]);
    n1 = mem[1]; n2 = mem[2]; n3 = mem[3]; n4 = mem[4]; n5 = mem[5]; n6 = mem[6];
    chr = 1'b0; cday = 1'b0; cmon = 1'b0; cyr = 1'b0;
    h12 = bcd_inc({3'b000, mem[2][4:0]});
    h24 = bcd_inc({2'b00, mem[2][5:0]});
    if (cmin) begin
      if (mem[1] == 8'h59) begin n1 = 8'h00; chr = 1'b1; end
      else n1 = bcd_inc(mem[1]);
    end
    if (chr) begin
      if (mem[2][6]) begin
        if (mem[2][4:0] == 5'h11) begin
          n2 = {mem[2][7:6], ~mem[2][5], 5'h12};
          cday = mem[2][5];
        end else if (mem[2][4:0] == 5'h12) n2 = {mem[2][7:5], 5'h01};
        else n2 = {mem[2][7:5], 5'b0} | h12;
      end else begin
        if (mem[2][5:0] == 6'h23) begin n2 = {mem[2][7:6], 6'h00}; cday = 1'b1; end
        else n2 = {mem[2][7:6], 6'b0} | h24;
      end
    end
    if (cday) begin
      n3 = (mem[3] == 8'h07) ? 8'h01 : mem[3] + 8'h01;
      if (mem[4] == mlen(mem[5], mem[6])) begin n4 = 8'h01; cmon = 1'b1; end
      else n4 = bcd_inc(mem[4]);
    end
    if (cmon) begin
      if (mem[5] == 8'h12) begin n5 = 8'h01; cyr = 1'b1; end
      else n5 = bcd_inc(mem[5]);
    end
    if (cyr) n6 = (mem[6] == 8'h99) ? 8'h00 : bcd_inc(mem[6]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      sub <= '0;
    end else begin
      if (wr_en && ptr == '0) sub <= '0;
      else if (tick_i && !halted) sub <= (sub == SW'(SUBTICKS - 1)) ? '0 : sub + 1'b1;
      if (sec_step) begin
        mem[0] <= n0; mem[1] <= n1; mem[2] <= n2; mem[3] <= n3;
        mem[4] <= n4; mem[5] <= n5; mem[6] <= n6;
      end
      if (wr_en) mem[ptr] <= sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111; sda_q <= 3'b111;
      st <= S_IDLE; ptr <= '0; sda_oe <= 1'b0; cnt <= '0;
      sh <= '0; tx <= '0; rw <= 1'b0; first <= 1'b0; mack <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (!pwr_ok) begin
        st <= S_IDLE; ptr <= '0; sda_oe <= 1'b0;
      end else if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; first <= 1'b1;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_q[1]};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  st <= S_ACK; sda_oe <= 1'b1; rw <= sh[0];
                end else st <= S_IDLE;
              end else begin
                st <= S_ACK; sda_oe <= 1'b1;
                if (first) begin ptr <= sh[AW-1:0]; first <= 1'b0; end
                else ptr <= ptr + 1'b1;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= S_RD; tx <= mem[ptr]; ptr <= ptr + 1'b1; sda_oe <= ~mem[ptr][7];
            end else begin
              st <= S_WR; sda_oe <= 1'b0;
            end
          end
          S_RD: if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= S_RACK; sda_oe <= 1'b0;
            end else begin
              sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_q[1];
            else if (scl_fall) begin
              if (mack) begin
                st <= S_RD; tx <= mem[ptr]; ptr <= ptr + 1'b1;
                sda_oe <= ~mem[ptr][7]; cnt <= '0;
              end else st <= S_IDLE;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!sda_oe && ptr == '0)); // R12
  AST_HALT_FREEZES_SECONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_en) |=> $stable(mem[0])); // R6
  AST_STOP_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && stop_c) |=> (st == S_IDLE && !sda_oe)); // R5
  AST_DRIVE_ONLY_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_ACK || st == S_RD)); // R1
  AST_SEC_WRITE_CLEARS_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == '0) |=> sub == '0); // R11
endmodule

// File: tb/rtc_regfile_i2c_bench.sv
module rtc_regfile_i2c_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h68;
  localparam int SUB = 4;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_low = 1'b0, tick = 1'b0, pwr_ok = 1'b1;
  wire sda_oe;
  wire sda_bus = ~(m_low | sda_oe);
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regfile_i2c #(.DEV_ADDR(DEV), .SUBTICKS(SUB), .AW(6)) u_rtc_regfile_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .tick_i(tick), .pwr_ok(pwr_ok));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g;
        g = got_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "unexpected byte", g, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(g == e, t, g, e);
        end
      end
    end
  end

  task automatic waitq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    m_low = 1'b0; waitq(); m_scl = 1'b1; waitq(); m_low = 1'b1; waitq(); m_scl = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; waitq(); m_scl = 1'b1; waitq(); m_low = 1'b0; waitq(); waitq();
  endtask

  task automatic put_bit(bit b, output bit seen);
    m_low = !b; waitq(); m_scl = 1'b1; waitq(); seen = sda_bus; waitq(); m_scl = 1'b0; waitq();
  endtask

  task automatic put_byte(logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(v[i], s);
    put_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic get_byte(bit ack, output logic [7:0] v);
    bit s;
    v = '0;
    for (int i = 7; i >= 0; i--) begin put_bit(1'b1, s); v[i] = s; end
    put_bit(!ack, s);
  endtask

  task automatic expect_bytes(logic [7:0] d[$], string tag);
    foreach (d[i]) begin exp_q.push_back(d[i]); tag_q.push_back(tag); end
  endtask

  task automatic wr_regs(logic [7:0] p, logic [7:0] d[$], string tag);
    bit a;
    i2c_start();
    put_byte({DEV, 1'b0}, a); chk(a, {tag, " addr ack R1"}, a, 1);
    put_byte(p, a); chk(a, {tag, " ptr ack R2"}, a, 1);
    foreach (d[i]) begin put_byte(d[i], a); chk(a, {tag, " data ack R2"}, a, 1); end
    i2c_stop();
  endtask

  task automatic rd_regs(int n, bit set_ptr, logic [7:0] p);
    bit a;
    logic [7:0] v;
    i2c_start();
    if (set_ptr) begin
      put_byte({DEV, 1'b0}, a);
      put_byte(p, a);
      i2c_start();
    end
    put_byte({DEV, 1'b1}, a); chk(a, "read addr ack R1", a, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, v);
      got_q.push_back(v);
    end
    waitq();
    chk(sda_oe == 1'b0, "released after NACK R3", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic ticks(int n);
    repeat (n) begin @(negedge clk) tick = 1'b1; @(negedge clk) tick = 1'b0; end
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && sda_bus == 1'b1, "reset releases SDA R5", sda_oe, 0);

    i2c_start();
    put_byte({7'h50, 1'b0}, a);
    chk(!a, "foreign address not acked R1", a, 0);
    i2c_stop();

    wr_regs(8'h10, '{8'h01, 8'hAA, 8'hC3, 8'h77}, "R2 write");
    expect_bytes('{8'h01, 8'hAA, 8'hC3}, "R2 R5 stored bytes, MSB first");
    rd_regs(3, 1'b1, 8'h10);
    expect_bytes('{8'h77}, "R3 read resumes at pointer");
    rd_regs(1, 1'b0, 8'h00);

    wr_regs(8'h3F, '{8'h5A, 8'h80}, "R4 wrap write");
    expect_bytes('{8'h5A, 8'h80}, "R4 wrap 3F to 00");
    rd_regs(2, 1'b1, 8'h3F);

    ticks(8);
    expect_bytes('{8'h80}, "R6 halted seconds");
    rd_regs(1, 1'b1, 8'h00);

    wr_regs(8'h07, '{8'h93}, "R13 write");
    wr_regs(8'h00, '{8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23}, "R7 set");
    ticks(SUB);
    expect_bytes('{8'h59}, "R7 one second");
    rd_regs(1, 1'b1, 8'h00);
    ticks(SUB);
    expect_bytes('{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23},
                 "R8 R10 midnight, Feb 28 non-leap");
    expect_bytes('{8'h93}, "R13 byte 07 untouched");
    rd_regs(8, 1'b1, 8'h00);

    wr_regs(8'h00, '{8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24}, "R10 set");
    ticks(SUB);
    expect_bytes('{8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24}, "R10 leap Feb 29");
    rd_regs(7, 1'b1, 8'h00);

    wr_regs(8'h00, '{8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99}, "R10 set");
    ticks(SUB);
    expect_bytes('{8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h01, 8'h00}, "R10 year rollover");
    rd_regs(7, 1'b1, 8'h00);

    wr_regs(8'h00, '{8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h25}, "R10 set");
    ticks(SUB);
    expect_bytes('{8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h25}, "R10 30-day month");
    rd_regs(7, 1'b1, 8'h00);

    wr_regs(8'h00, '{8'h59, 8'h59, 8'h19}, "R8 set");
    ticks(SUB);
    expect_bytes('{8'h00, 8'h00, 8'h20}, "R8 19 to 20");
    rd_regs(3, 1'b1, 8'h00);

    wr_regs(8'h00, '{8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h05, 8'h25}, "R9 set");
    ticks(SUB);
    expect_bytes('{8'h00, 8'h00, 8'h72, 8'h02, 8'h10}, "R9 11AM to 12PM");
    rd_regs(5, 1'b1, 8'h00);
    wr_regs(8'h00, '{8'h59, 8'h59, 8'h71}, "R9 set");
    ticks(SUB);
    expect_bytes('{8'h00, 8'h00, 8'h52, 8'h03, 8'h11}, "R9 11PM to 12AM");
    rd_regs(5, 1'b1, 8'h00);
    wr_regs(8'h00, '{8'h59, 8'h59, 8'h52}, "R9 set");
    ticks(SUB);
    expect_bytes('{8'h00, 8'h00, 8'h41}, "R9 12AM to 1AM");
    rd_regs(3, 1'b1, 8'h00);

    wr_regs(8'h00, '{8'h10}, "R11 set");
    ticks(SUB - 1);
    wr_regs(8'h00, '{8'h10}, "R11 rewrite");
    ticks(SUB - 1);
    expect_bytes('{8'h10}, "R11 sub-second restarted");
    rd_regs(1, 1'b1, 8'h00);
    ticks(1);
    expect_bytes('{8'h11}, "R11 full second after rewrite");
    rd_regs(1, 1'b1, 8'h00);

    wr_regs(8'h00, '{8'h00}, "R12 set");
    i2c_start();
    put_byte({DEV, 1'b0}, a); chk(a, "R12 addr ack", a, 1);
    put_byte(8'h20, a); chk(a, "R12 ptr ack", a, 1);
    put_byte(8'h11, a); chk(a, "R12 data ack", a, 1);
    pwr_ok = 1'b0;
    put_byte(8'h99, a);
    chk(!a, "R12 byte ignored after power loss", a, 0);
    i2c_stop();
    i2c_start();
    put_byte({DEV, 1'b0}, a);
    chk(!a, "R12 address ignored without power", a, 0);
    i2c_stop();
    ticks(SUB);
    chk(sda_oe == 1'b0, "R12 SDA released without power", sda_oe, 0);
    pwr_ok = 1'b1;
    waitq();
    expect_bytes('{8'h01}, "R12 pointer reset, clock kept counting");
    rd_regs(1, 1'b0, 8'h00);
    expect_bytes('{8'h11, 8'h00}, "R12 aborted byte not stored");
    rd_regs(2, 1'b1, 8'h20);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "all expected bytes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule